// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits in front of the arithmetic datapath of a double-precision fused multiply-add unit computing an addend plus or minus a product (z ± x·y). It does not see the operand bits. It sees a pre-computed class code and a sign for each of the three operands, two negation controls and the rounding mode. From these it decides whether the answer is fixed by the special-value rules. The fixed cases are NaN propagation, invalid combinations, infinities, and exact zeros whose sign depends on rounding. In every other case it hands the operation to the datapath.

One request is accepted per clock when `inValid` is high, and the decision appears on the registered outputs one cycle later. If a result can bypass the datapath, `resultSel` names its source: one of the three operands, the default NaN, an infinity or a zero. `resultSign` gives the sign to apply. Two further flags report an invalid operation and whether a signalling NaN must be quieted. The effective product sign is `signX ^ signY ^ negProd`. The effective addend sign is `signZ ^ negAdd`.

Top module: `fmaSpecResolver`

## Requirements
- R1: While `rstN` is low, and until the first accepted request, every output is 0.
- R2: `outValid` is high exactly in the cycle after a cycle with `inValid` high. When `inValid` is low, all other outputs keep their previous values.
- R3: Class codes are zero=0, normal=1, subnormal=2, infinity=3, quiet NaN=4, signalling NaN=5. A signalling NaN takes priority in the order z, x, y. The operand is selected (`resultSel` z=1, x=2, y=3), its raw sign is output, and both `invalidOp` and `quietNan` are set.
- R4: If there is no signalling NaN, a quiet NaN is selected in the order z, x, y, with its raw sign and with both flags clear.
- R5: An infinity multiplied by a zero, in either order, gives the default NaN (`resultSel`=4) with sign 0 and `invalidOp` set.
- R6: An infinite product (no zero factor) with an infinite z of the opposite effective sign gives the default NaN with `invalidOp` set. Otherwise it gives infinity (`resultSel`=5) with the effective product sign.
- R7: A zero product with an infinite z gives infinity with the effective addend sign. A zero product with a normal or subnormal z selects z with the effective addend sign.
- R8: A zero product with a zero z of the same effective sign selects z with that sign. With opposite effective signs the result is zero (`resultSel`=6), with sign 1 only when `roundMode`=3 (toward minus infinity).
- R9: A finite nonzero product with an infinite z gives infinity with the effective addend sign.
- R10: In every other case `bypass` is 0, and `resultSel`, `resultSign`, `invalidOp` and `quietNan` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| classZ | input | 3 | Addend class code |
| classX | input | 3 | First factor class code |
| classY | input | 3 | Second factor class code |
| signZ | input | 1 | Addend raw sign |
| signX | input | 1 | First factor raw sign |
| signY | input | 1 | Second factor raw sign |
| negProd | input | 1 | Invert the product sign |
| negAdd | input | 1 | Invert the addend sign |
| roundMode | input | 2 | Rounding mode; 3 = toward minus infinity |
| outValid | output | 1 | Decision valid |
| bypass | output | 1 | Result fixed without the datapath |
| resultSel | output | 3 | 0 none, 1 z, 2 x, 3 y, 4 default NaN, 5 infinity, 6 zero |
| resultSign | output | 1 | Sign of the selected result |
| invalidOp | output | 1 | Invalid-operation flag |
| quietNan | output | 1 | Selected signalling NaN must be quieted |

## Verification
Several rules can apply to one request at once. The most common overlaps are a NaN together with an infinity-times-zero product, and an infinite product against an infinite addend, where the negation controls decide between the default NaN and a signed infinity. The bench provokes these overlaps by sweeping every combination of the three class codes, the three signs, both negation controls and all rounding modes. It judges each cycle against a reference model that resolves the rules by explicit precedence. Idle cycles are interleaved so that holding and latency are checked in the same run.

// File: rtl/fmaSpecPkg.sv
package fmaSpecPkg;
  localparam int CLS_W = 3;
  localparam int RM_W  = 2;

  localparam logic [CLS_W-1:0] CLS_ZERO = 3'd0;
  localparam logic [CLS_W-1:0] CLS_NORM = 3'd1;
  localparam logic [CLS_W-1:0] CLS_SUB  = 3'd2;
  localparam logic [CLS_W-1:0] CLS_INF  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_QNAN = 3'd4;
  localparam logic [CLS_W-1:0] CLS_SNAN = 3'd5;

  localparam logic [RM_W-1:0] RM_DOWN = 2'd3;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0, SEL_Z = 3'd1, SEL_X = 3'd2, SEL_Y = 3'd3,
    SEL_DNAN = 3'd4, SEL_INF = 3'd5, SEL_ZERO = 3'd6
  } resSel_t;

  localparam int SEL_W = $bits(resSel_t);

  typedef enum logic [2:0] {
    SGN_POS, SGN_PROD, SGN_ADDEND, SGN_RAWZ, SGN_RAWX, SGN_RAWY, SGN_ROUND
  } sgnSrc_t;

  typedef struct packed {
    logic    load;
    logic    bypass;
    resSel_t sel;
    sgnSrc_t sgnSrc;
    logic    invalid;
    logic    quiet;
  } strobe_t;
endpackage

// File: rtl/fmaSpecCtrl.sv
module fmaSpecCtrl
  import fmaSpecPkg::*;
(
  input  logic             inValid,
  input  logic [CLS_W-1:0] classZ,
  input  logic [CLS_W-1:0] classX,
  input  logic [CLS_W-1:0] classY,
  input  logic             effDiffer,
  output strobe_t          strobe
);
  logic prodInf, prodZero;

  assign prodInf  = (classX == CLS_INF)  || (classY == CLS_INF);
  assign prodZero = (classX == CLS_ZERO) || (classY == CLS_ZERO);

  always_comb begin
    strobe = '0;
    strobe.load = inValid;
    strobe.bypass = 1'b1;
    if (classZ == CLS_SNAN) begin
      strobe.sel = SEL_Z; strobe.sgnSrc = SGN_RAWZ;
      strobe.invalid = 1'b1; strobe.quiet = 1'b1;
    end else if (classX == CLS_SNAN) begin
      strobe.sel = SEL_X; strobe.sgnSrc = SGN_RAWX;
      strobe.invalid = 1'b1; strobe.quiet = 1'b1;
    end else if (classY == CLS_SNAN) begin
      strobe.sel = SEL_Y; strobe.sgnSrc = SGN_RAWY;
      strobe.invalid = 1'b1; strobe.quiet = 1'b1;
    end else if (classZ == CLS_QNAN) begin
      strobe.sel = SEL_Z; strobe.sgnSrc = SGN_RAWZ;
    end else if (classX == CLS_QNAN) begin
      strobe.sel = SEL_X; strobe.sgnSrc = SGN_RAWX;
    end else if (classY == CLS_QNAN) begin
      strobe.sel = SEL_Y; strobe.sgnSrc = SGN_RAWY;
    end else if (prodInf && prodZero) begin
      strobe.sel = SEL_DNAN; strobe.sgnSrc = SGN_POS; strobe.invalid = 1'b1;
    end else if (prodInf) begin
      if ((classZ == CLS_INF) && effDiffer) begin
        strobe.sel = SEL_DNAN; strobe.sgnSrc = SGN_POS; strobe.invalid = 1'b1;
      end else begin
        strobe.sel = SEL_INF; strobe.sgnSrc = SGN_PROD;
      end
    end else if (classZ == CLS_INF) begin
      strobe.sel = SEL_INF; strobe.sgnSrc = SGN_ADDEND;
    end else if (prodZero) begin
      if ((classZ == CLS_ZERO) && effDiffer) begin
        strobe.sel = SEL_ZERO; strobe.sgnSrc = SGN_ROUND;
      end else begin
        strobe.sel = SEL_Z; strobe.sgnSrc = SGN_ADDEND;
      end
    end else begin
      strobe.bypass = 1'b0;
      strobe.sel = SEL_NONE; strobe.sgnSrc = SGN_POS;
    end
  end
endmodule

// File: rtl/fmaSpecData.sv
module fmaSpecData
  import fmaSpecPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             signZ,
  input  logic             signX,
  input  logic             signY,
  input  logic             negProd,
  input  logic             negAdd,
  input  logic [RM_W-1:0]  roundMode,
  output logic             effDiffer,
  output logic             outValid,
  output logic             bypass,
  output logic [SEL_W-1:0] resultSel,
  output logic             resultSign,
  output logic             invalidOp,
  output logic             quietNan
);
  logic prodSign, addSign, nextSign;

  assign prodSign  = signX ^ signY ^ negProd;
  assign addSign   = signZ ^ negAdd;
  assign effDiffer = prodSign ^ addSign;

  always_comb begin
    unique case (strobe.sgnSrc)
      SGN_PROD:   nextSign = prodSign;
      SGN_ADDEND: nextSign = addSign;
      SGN_RAWZ:   nextSign = signZ;
      SGN_RAWX:   nextSign = signX;
      SGN_RAWY:   nextSign = signY;
      SGN_ROUND:  nextSign = (roundMode == RM_DOWN);
      default:    nextSign = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      bypass     <= 1'b0;
      resultSel  <= '0;
      resultSign <= 1'b0;
      invalidOp  <= 1'b0;
      quietNan   <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        bypass     <= strobe.bypass;
        resultSel  <= strobe.sel;
        resultSign <= nextSign;
        invalidOp  <= strobe.invalid;
        quietNan   <= strobe.quiet;
      end
    end
  end
endmodule

// File: rtl/fmaSpecResolver.sv
module fmaSpecResolver
  import fmaSpecPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CLS_W-1:0] classZ,
  input  logic [CLS_W-1:0] classX,
  input  logic [CLS_W-1:0] classY,
  input  logic             signZ,
  input  logic             signX,
  input  logic             signY,
  input  logic             negProd,
  input  logic             negAdd,
  input  logic [RM_W-1:0]  roundMode,
  output logic             outValid,
  output logic             bypass,
  output logic [SEL_W-1:0] resultSel,
  output logic             resultSign,
  output logic             invalidOp,
  output logic             quietNan
);
  strobe_t strobe;
  logic    effDiffer;

  fmaSpecCtrl ctrl (
    .inValid(inValid), .classZ(classZ), .classX(classX), .classY(classY),
    .effDiffer(effDiffer), .strobe(strobe)
  );

  fmaSpecData data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .signZ(signZ), .signX(signX), .signY(signY),
    .negProd(negProd), .negAdd(negAdd), .roundMode(roundMode),
    .effDiffer(effDiffer), .outValid(outValid), .bypass(bypass),
    .resultSel(resultSel), .resultSign(resultSign),
    .invalidOp(invalidOp), .quietNan(quietNan)
  );
endmodule

// File: rtl/fmaSpecChk.sv
module fmaSpecChk
  import fmaSpecPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [CLS_W-1:0] classZ,
  input logic [CLS_W-1:0] classX,
  input logic [CLS_W-1:0] classY,
  input logic             signZ,
  input logic             signX,
  input logic             signY,
  input logic             negProd,
  input logic             negAdd,
  input logic [RM_W-1:0]  roundMode,
  input logic             outValid,
  input logic             bypass,
  input logic [SEL_W-1:0] resultSel,
  input logic             resultSign,
  input logic             invalidOp,
  input logic             quietNan
);
  // R2
  out_valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(resultSel) && $stable(resultSign) && $stable(bypass)));
  // R3
  snan_z_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && classZ == CLS_SNAN) |=> (quietNan && invalidOp && resultSel == SEL_Z));
  // R3
  quiet_needs_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietNan |-> (invalidOp && bypass));
  // R5
  invalid_gives_dnan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invalidOp && !quietNan) |-> (resultSel == SEL_DNAN && !resultSign));
  // R8
  zero_round_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && classZ == CLS_ZERO && classX == CLS_ZERO &&
     (classY == CLS_ZERO || classY == CLS_NORM || classY == CLS_SUB) &&
     ((signX ^ signY ^ negProd) != (signZ ^ negAdd)))
    |=> (resultSel == SEL_ZERO && resultSign == $past(roundMode == RM_DOWN)));
  // R10
  no_bypass_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bypass |-> (resultSel == SEL_NONE && !resultSign && !invalidOp && !quietNan));
endmodule

bind fmaSpecResolver fmaSpecChk chk (.*);

// File: tb/fmaSpecResolver_test.sv
module fmaSpecResolver_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] classZ = 3'd0, classX = 3'd0, classY = 3'd0;
  logic signZ = 1'b0, signX = 1'b0, signY = 1'b0;
  logic negProd = 1'b0, negAdd = 1'b0;
  logic [1:0] roundMode = 2'd0;
  logic outValid, bypass, resultSign, invalidOp, quietNan;
  logic [2:0] resultSel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected registered state
  logic [6:0] expState = '0;
  logic       expValid = 1'b0;
  string      expTag = "R1";

  always #5 clk = ~clk;

  fmaSpecResolver uut (.*);

  function automatic bit isNanCode(int c);
    return c == 4 || c == 5;
  endfunction

  task automatic refModel(input int cz, cx, cy, input bit sz, sx, sy, np, na,
                          input int rm, output logic [6:0] res, output string tag);
    int  codes[3];
    bit  raw[3];
    bit  pSign, aSign;
    bit  found;
    int  pick;
    bit  anyInf, anyZero;
    codes[0] = cz; codes[1] = cx; codes[2] = cy;
    raw[0] = sz; raw[1] = sx; raw[2] = sy;
    pSign = sx ^ sy ^ np;
    aSign = sz ^ na;
    found = 0; pick = 0;
    // fields: bypass, sel[2:0], sign, invalid, quiet
    for (int i = 0; i < 3; i++)
      if (!found && codes[i] == 5) begin found = 1; pick = i; end
    if (found) begin
      res = {1'b1, 3'(pick + 1), raw[pick], 1'b1, 1'b1}; tag = "R3"; return;
    end
    for (int i = 0; i < 3; i++)
      if (!found && codes[i] == 4) begin found = 1; pick = i; end
    if (found) begin
      res = {1'b1, 3'(pick + 1), raw[pick], 1'b0, 1'b0}; tag = "R4"; return;
    end
    anyInf = (cx == 3) || (cy == 3);
    anyZero = (cx == 0) || (cy == 0);
    if (anyInf && anyZero) begin
      res = {1'b1, 3'd4, 1'b0, 1'b1, 1'b0}; tag = "R5";
    end else if (anyInf) begin
      tag = "R6";
      if (cz == 3 && pSign != aSign) res = {1'b1, 3'd4, 1'b0, 1'b1, 1'b0};
      else res = {1'b1, 3'd5, pSign, 1'b0, 1'b0};
    end else if (anyZero) begin
      if (cz == 3) begin res = {1'b1, 3'd5, aSign, 1'b0, 1'b0}; tag = "R7"; end
      else if (cz == 0) begin
        tag = "R8";
        if (pSign == aSign) res = {1'b1, 3'd1, aSign, 1'b0, 1'b0};
        else res = {1'b1, 3'd6, (rm == 3) ? 1'b1 : 1'b0, 1'b0, 1'b0};
      end else begin res = {1'b1, 3'd1, aSign, 1'b0, 1'b0}; tag = "R7"; end
    end else if (cz == 3) begin
      res = {1'b1, 3'd5, aSign, 1'b0, 1'b0}; tag = "R9";
    end else begin
      res = '0; tag = "R10";
    end
    if (isNanCode(cz)) tag = "R4";
  endtask

  task automatic compareNow();
    logic [6:0] act;
    act = {bypass, resultSel, resultSign, invalidOp, quietNan};
    total++;
    if (act !== expState || outValid !== expValid) begin
      bad++;
      $display("FAIL %s: actual valid=%0b out=%b expected valid=%0b out=%b (z=%0d x=%0d y=%0d)",
               expTag, outValid, act, expValid, expState, classZ, classX, classY);
    end
  endtask

  task automatic step(input bit v);
    logic [6:0] nxt;
    string t;
    inValid = v;
    refModel(int'(classZ), int'(classX), int'(classY), signZ, signX, signY,
             negProd, negAdd, int'(roundMode), nxt, t);
    @(posedge clk);
    #2;
    expValid = v;
    if (v) begin expState = nxt; expTag = t; end
    else expTag = "R2";
    compareNow();
    @(negedge clk);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    expTag = "R1";
    compareNow();  // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    compareNow();  // R1 after release, before any request
    step(1'b0);    // R2 idle keeps reset state
    for (int cz = 0; cz < 6; cz++)
      for (int cx = 0; cx < 6; cx++)
        for (int cy = 0; cy < 6; cy++)
          for (int sg = 0; sg < 32; sg++)
            for (int rm = 0; rm < 4; rm++) begin
              classZ = 3'(cz); classX = 3'(cx); classY = 3'(cy);
              {signZ, signX, signY, negProd, negAdd} = 5'(sg);
              roundMode = 2'(rm);
              step(1'b1);
              n++;
              if (n % 7 == 0) begin
                // R2: change inputs while idle; outputs must hold
                classZ = 3'd5; signZ = ~signZ;
                step(1'b0);
              end
            end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule